// File: doc/BRIEF.md
# Fully Associative Block Cache with Pointer Replacement

This block holds 64 cache blocks of 32 bytes each. There is no set index. A lookup address is cut into a 27-bit tag and a 5-bit byte offset. That tag is compared with the stored tag of every entry at once. A match on a valid entry reports a hit in the same cycle, along with the entry number and the 32-bit word picked by the offset. When more than one entry would match, the lowest-numbered entry is reported.

Replacement uses one round-robin style pointer. The pointer moves to the next entry only when a lookup hits the entry it currently names. A refill of a tag that is not resident writes the block into the entry under the pointer, which evicts whatever was there, and then moves the pointer. A refill of a tag that is already resident overwrites that entry in place, so a tag is never stored twice. The pointer is visible at a port so the caller can see which entry a refill will replace.

Top module: `fa_cache`

## Requirements
- R1: A 32-bit address splits into tag bits [31:5] and byte offset bits [4:0]. Offset bits [4:2] select which 32-bit word of the block appears on `rd_word`. Word k occupies bits [32k+31:32k] of the refill block.
- R2: `rd_hit` is high in the same cycle as `rd_req` exactly when a valid entry holds the address tag. On a hit, `rd_entry` gives that entry's number. `rd_hit` is low whenever `rd_req` is low.
- R3: At most one valid entry ever holds a given tag.
- R4: The pointer advances by one after a cycle in which a lookup hits the entry it names. A lookup that misses, or hits any other entry, leaves the pointer unchanged.
- R5: A refill whose tag is not resident writes the block and tag into the entry named by `victim`, marks that entry valid, and advances the pointer by one. The previous occupant of that entry then misses.
- R6: The pointer wraps from entry 63 to entry 0.
- R7: A refill whose tag is already resident overwrites that entry's data and leaves the pointer unchanged.
- R8: A synchronous active-low reset invalidates all entries and sets the pointer to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_req | input | 1 | Lookup request |
| rd_addr | input | 32 | Lookup byte address |
| rd_hit | output | 1 | Lookup hit (combinational) |
| rd_entry | output | 6 | Entry number of the hit |
| rd_word | output | 32 | Word selected from the hit block |
| fill_req | input | 1 | Refill request |
| fill_addr | input | 32 | Address of the block being refilled |
| fill_block | input | 256 | Refill block data, word k at bits [32k+31:32k] |
| victim | output | 6 | Current replacement pointer |

## Verification
The bench fills the whole cache until the pointer wraps from 63 to 0. A design that forgets the wrap would leave the pointer out of range or stuck. It then separates lookups that hit the pointed-at entry from lookups that hit other entries. A pointer that moves on every hit, or never moves, shows up as the wrong `victim`. It checks that the entry evicted by a refill now misses, and that a refill of a resident tag leaves the pointer alone. A design that instead filled the victim slot would leave two copies of the tag and show a stale word. Finally it reset-checks a full cache, where surviving valid bits would appear as hits.

// File: rtl/fa_pkg.sv
// Package fa_pkg
// Purpose : default geometry shared by the fully associative cache modules.
// Assumes : block size and word size are powers of two.
package fa_pkg;
    localparam int unsigned DEF_ADDR_W      = 32;
    localparam int unsigned DEF_ENTRIES     = 64;
    localparam int unsigned DEF_BLOCK_BYTES = 32;
    localparam int unsigned DEF_WORD_W      = 32;
endpackage

// File: rtl/fa_tag_match.sv
// Module  : fa_tag_match
// Purpose : compares one key tag against every stored tag in parallel and
//           encodes the match vector into an entry number. The lowest index wins.
// Assumes : purely combinational; the caller qualifies with its request.
module fa_tag_match #(
    parameter int unsigned ENTRIES = 64,
    parameter int unsigned TAG_W   = 27,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0]            valid,
    input  logic [ENTRIES-1:0][TAG_W-1:0] tags,
    input  logic [TAG_W-1:0]              key,
    output logic [ENTRIES-1:0]            match,
    output logic                          any,
    output logic [IDX_W-1:0]              idx
);
    // one comparator per entry
    for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
        assign match[e] = valid[e] && (tags[e] == key);
    end

    assign any = |match;

    // priority encoder: lowest matching entry
    always_comb begin
        idx = '0;
        for (int e = ENTRIES - 1; e >= 0; e--) begin
            if (match[e]) idx = IDX_W'(e);
        end
    end
endmodule

// File: rtl/fa_repl_ptr.sv
// Module  : fa_repl_ptr
// Purpose : the single replacement pointer. It advances by one, wrapping at
//           the last entry, on cycles where step is high.
// Assumes : step is computed by the parent from hits and refills.
module fa_repl_ptr #(
    parameter int unsigned ENTRIES = 64,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [IDX_W-1:0] ptr
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    // pointer register with wrap
    always_ff @(posedge clk) begin
        if (!rst_n)    ptr <= '0;
        else if (step) ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end

    // R6
    ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && ptr == LAST) |=> (ptr == '0));
    // R4
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(ptr));
endmodule

// File: rtl/fa_store.sv
// Module  : fa_store
// Purpose : valid bits, tags and block data for all entries; one write port.
// Assumes : only valid bits are reset; data and tags are qualified by valid.
module fa_store #(
    parameter int unsigned ENTRIES = 64,
    parameter int unsigned TAG_W   = 27,
    parameter int unsigned BLK_W   = 256,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [IDX_W-1:0]              wr_idx,
    input  logic [TAG_W-1:0]              wr_tag,
    input  logic [BLK_W-1:0]              wr_blk,
    output logic [ENTRIES-1:0]            valid,
    output logic [ENTRIES-1:0][TAG_W-1:0] tags,
    output logic [ENTRIES-1:0][BLK_W-1:0] data
);
    // valid bits: cleared by reset, set by a write
    always_ff @(posedge clk) begin
        if (!rst_n)     valid <= '0;
        else if (wr_en) valid[wr_idx] <= 1'b1;
    end

    // tag and data arrays
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tags[wr_idx] <= wr_tag;
            data[wr_idx] <= wr_blk;
        end
    end
endmodule

// File: rtl/fa_cache.sv
// Module  : fa_cache
// Purpose : fully associative cache. It does a parallel tag lookup, returns
//           the selected word, refills under a pointer, and moves the pointer
//           only when the entry it names is hit.
// Assumes : refill data arrives as a whole block in one cycle.
module fa_cache
    import fa_pkg::*;
#(
    parameter int unsigned ADDR_W      = DEF_ADDR_W,
    parameter int unsigned ENTRIES     = DEF_ENTRIES,
    parameter int unsigned BLOCK_BYTES = DEF_BLOCK_BYTES,
    parameter int unsigned WORD_W      = DEF_WORD_W,
    localparam int unsigned OFF_W  = $clog2(BLOCK_BYTES),
    localparam int unsigned TAG_W  = ADDR_W - OFF_W,
    localparam int unsigned IDX_W  = $clog2(ENTRIES),
    localparam int unsigned BLK_W  = BLOCK_BYTES * 8,
    localparam int unsigned BYTE_W = $clog2(WORD_W / 8),
    localparam int unsigned WSEL_W = OFF_W - BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_hit,
    output logic [IDX_W-1:0]  rd_entry,
    output logic [WORD_W-1:0] rd_word,
    input  logic              fill_req,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic [BLK_W-1:0]  fill_block,
    output logic [IDX_W-1:0]  victim
);
    logic [ENTRIES-1:0]            valid;
    logic [ENTRIES-1:0][TAG_W-1:0] tags;
    logic [ENTRIES-1:0][BLK_W-1:0] data;
    logic [ENTRIES-1:0]            rd_match, fl_match;
    logic                          rd_any, fl_any;
    logic [IDX_W-1:0]              rd_idx, fl_idx;
    logic [WSEL_W-1:0]             wsel;
    logic                          step, wr_en;
    logic [IDX_W-1:0]              wr_idx;
    logic                          unused_bits;

    assign unused_bits = ^{rd_addr[BYTE_W-1:0], fill_addr[OFF_W-1:0]};

    fa_tag_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_rd_match (
        .valid(valid), .tags(tags), .key(rd_addr[ADDR_W-1:OFF_W]),
        .match(rd_match), .any(rd_any), .idx(rd_idx));

    fa_tag_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_fl_match (
        .valid(valid), .tags(tags), .key(fill_addr[ADDR_W-1:OFF_W]),
        .match(fl_match), .any(fl_any), .idx(fl_idx));

    // lookup response
    assign rd_hit   = rd_req && rd_any;
    assign rd_entry = rd_idx;
    assign wsel     = rd_addr[OFF_W-1:BYTE_W];
    assign rd_word  = data[rd_idx][wsel*WORD_W +: WORD_W];

    // refill steering: resident tag overwrites in place, else use the victim
    assign wr_en  = fill_req;
    assign wr_idx = fl_any ? fl_idx : victim;

    // pointer step: hit on the pointed entry, or a refill into the victim
    assign step = (rd_hit && rd_entry == victim) || (fill_req && !fl_any);

    fa_store #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .BLK_W(BLK_W)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_tag(fill_addr[ADDR_W-1:OFF_W]), .wr_blk(fill_block),
        .valid(valid), .tags(tags), .data(data));

    fa_repl_ptr #(.ENTRIES(ENTRIES)) u_ptr (
        .clk(clk), .rst_n(rst_n), .step(step), .ptr(victim));

    // R3
    single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rd_match));
    // R4
    ptr_hit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit && rd_entry == victim && !fill_req && victim != IDX_W'(ENTRIES-1))
        |=> (victim == $past(victim) + 1'b1));
    // R5
    fill_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req && !fl_any) |=> valid[$past(victim)]);
    // R7
    refill_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req && fl_any && !rd_hit) |=> $stable(victim));
endmodule

// File: tb/sim_fa_cache.sv
`timescale 1ns/1ps
module sim_fa_cache;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         rd_req = 1'b0;
    logic [31:0]  rd_addr = '0;
    logic         rd_hit;
    logic [5:0]   rd_entry;
    logic [31:0]  rd_word;
    logic         fill_req = 1'b0;
    logic [31:0]  fill_addr = '0;
    logic [255:0] fill_block = '0;
    logic [5:0]   victim;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    fa_cache u0 (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_hit(rd_hit), .rd_entry(rd_entry), .rd_word(rd_word),
        .fill_req(fill_req), .fill_addr(fill_addr), .fill_block(fill_block),
        .victim(victim));

    typedef struct packed {
        logic        is_fill;
        logic [31:0] addr;
        logic [31:0] seed;
        logic        hit;
        logic [5:0]  entry;
        logic [31:0] word;
        logic [5:0]  ptr;
    } row_t;

    localparam row_t TBL [7] = '{
        '{1'b1, 32'h0000_1000, 32'h100, 1'b0, 6'd0, 32'h0,   6'd0},
        '{1'b1, 32'h0000_2020, 32'h200, 1'b0, 6'd0, 32'h0,   6'd1},
        '{1'b0, 32'h0000_1008, 32'h0,   1'b1, 6'd0, 32'h102, 6'd2},
        '{1'b1, 32'h1234_5640, 32'h300, 1'b0, 6'd0, 32'h0,   6'd2},
        '{1'b0, 32'h0000_203C, 32'h0,   1'b1, 6'd1, 32'h207, 6'd3},
        '{1'b0, 32'hFFFF_FFE0, 32'h0,   1'b0, 6'd0, 32'h0,   6'd3},
        '{1'b0, 32'h1234_5644, 32'h0,   1'b1, 6'd2, 32'h301, 6'd3}
    };

    function automatic logic [255:0] mk_block(input logic [31:0] seed);
        logic [255:0] b;
        for (int w = 0; w < 8; w++) b[w*32 +: 32] = seed + 32'(w);
        return b;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drive one operation after a falling edge; outputs settle 1 ns later
    task automatic apply(input bit is_fill, input logic [31:0] addr,
                         input logic [31:0] seed);
        @(negedge clk);
        fill_req   = is_fill;
        rd_req     = !is_fill;
        fill_addr  = addr;
        rd_addr    = addr;
        fill_block = mk_block(seed);
        #1;
    endtask

    task automatic idle();
        @(negedge clk);
        fill_req = 1'b0;
        rd_req   = 1'b0;
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R8 reset state
        chk(victim == 6'd0, "R8 ptr after reset", 32'(victim), 32'd0);
        apply(1'b0, 32'h0000_1000, 32'h0);
        chk(!rd_hit, "R8 empty after reset", 32'(rd_hit), 32'd0);

        // R1 R2 R4 R5 table walk
        foreach (TBL[i]) begin
            apply(TBL[i].is_fill, TBL[i].addr, TBL[i].seed);
            chk(victim == TBL[i].ptr, "R4 ptr in table", 32'(victim), 32'(TBL[i].ptr));
            if (!TBL[i].is_fill) begin
                chk(rd_hit == TBL[i].hit, "R2 hit in table", 32'(rd_hit), 32'(TBL[i].hit));
                if (TBL[i].hit) begin
                    chk(rd_entry == TBL[i].entry, "R2 entry in table",
                        32'(rd_entry), 32'(TBL[i].entry));
                    chk(rd_word == TBL[i].word, "R1 word in table", rd_word, TBL[i].word);
                end
            end
        end

        // R2: no hit without a request
        idle();
        chk(!rd_hit, "R2 hit without request", 32'(rd_hit), 32'd0);

        // R5 R6 fill the remaining entries, pointer wraps to 0
        for (int e = 3; e < 64; e++) apply(1'b1, 32'h0010_0000 + 32'(e * 32), 32'(e << 8));
        idle();
        chk(victim == 6'd0, "R6 ptr wrap", 32'(victim), 32'd0);

        // R4 hit on pointed entry advances
        apply(1'b0, 32'h0000_1000, 32'h0);
        chk(rd_hit && rd_entry == 6'd0, "R4 hit entry0", 32'(rd_entry), 32'd0);
        idle();
        chk(victim == 6'd1, "R4 advance on pointed hit", 32'(victim), 32'd1);

        // R4 hit on other entry does not advance
        apply(1'b0, 32'h0010_0000 + 32'(40 * 32) + 32'h1C, 32'h0);
        chk(rd_hit && rd_entry == 6'd40, "R2 hit entry40", 32'(rd_entry), 32'd40);
        chk(rd_word == 32'((40 << 8) + 7), "R1 word entry40", rd_word, 32'((40 << 8) + 7));
        idle();
        chk(victim == 6'd1, "R4 hold on other hit", 32'(victim), 32'd1);

        // R5 refill evicts entry1 (block B)
        apply(1'b1, 32'h0ABC_DE00, 32'h700);
        idle();
        chk(victim == 6'd2, "R5 ptr after refill", 32'(victim), 32'd2);
        apply(1'b0, 32'h0000_2020, 32'h0);
        chk(!rd_hit, "R5 evicted block misses", 32'(rd_hit), 32'd0);
        apply(1'b0, 32'h0ABC_DE0C, 32'h0);
        chk(rd_hit && rd_entry == 6'd1, "R5 new block in entry1", 32'(rd_entry), 32'd1);
        chk(rd_word == 32'h703, "R5 new block word", rd_word, 32'h703);

        // R7 refill of a resident tag overwrites in place
        apply(1'b1, 32'h0000_1000, 32'h900);
        idle();
        chk(victim == 6'd2, "R7 ptr unchanged", 32'(victim), 32'd2);
        apply(1'b0, 32'h0000_1010, 32'h0);
        chk(rd_hit && rd_entry == 6'd0, "R7 same entry", 32'(rd_entry), 32'd0);
        chk(rd_word == 32'h904, "R7 new data", rd_word, 32'h904);

        // R8 reset of a full cache
        @(negedge clk);
        rst_n = 1'b0;
        rd_req = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        apply(1'b0, 32'h0ABC_DE00, 32'h0);
        chk(!rd_hit, "R8 invalid after reset", 32'(rd_hit), 32'd0);
        chk(victim == 6'd0, "R8 ptr zero after reset", 32'(victim), 32'd0);
        idle();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (200000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule